// File: doc/BRIEF.md
# Timestamped Sensor Record Packetizer

This block turns converter samples into fixed 32-bit records for a streaming path toward a FIFO. Each record packs a sensor identifier, a data-length code, a 9-bit timestamp and a 16-bit sample. While the sampling enable is high, the block emits one record per sampling period. The period is a prescaler parameter counted in system-clock cycles. The default of 6250 cycles gives 50 us at 125 MHz.

The timestamp advances by one every period, including periods whose record could not be delivered. A host that reads the stream can therefore see any lost record as a gap in the timestamp sequence. A test-mode input replaces the sample with a fixed, easily recognised word, so that only the timestamp changes from one record to the next. Records leave through a single-entry valid/ready holding stage. A record that falls due while that stage is still occupied is dropped, and a sticky overflow flag is raised.

Top module: `sample_record_packer`

## Requirements
- R1: A record word places the sensor id in bits 31:27, the length code in bits 26:25, the timestamp in bits 24:16 and the sample in bits 15:0. All four fields are captured at the clock edge where the record falls due.
- R2: After the clock edge that first samples `sample_en_i` high, the first record falls due PERIOD_CYCLES edges later. Further records fall due every PERIOD_CYCLES edges while the enable stays high.
- R3: The first record after a restart carries timestamp 0. Each later period raises the timestamp by one, and after 511 it wraps to 0.
- R4: While `sample_en_i` is low, no record falls due: once the held record is taken, `rec_valid_o` stays low.
- R5: When `test_mode_i` is 1 at the due edge, the sample field holds the TEST_WORD parameter instead of `sample_i`.
- R6: A record that is offered with `rec_ready_i` low stays on `rec_data_o`, unchanged and with `rec_valid_o` high, until it is taken. `rec_valid_o` falls on the edge that completes a handshake, unless a new record loads at that same edge.
- R7: A record that falls due while the held record is valid and `rec_ready_i` is low is discarded, and `overflow_o` is set and stays set. The timestamp still advances for the dropped period.
- R8: A rising edge of `sample_en_i` clears the timestamp to 0, clears `overflow_o` and restarts the period count.
- R9: After reset, `rec_valid_o`, `rec_data_o` and `overflow_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en_i | input | 1 | Sampling enable; a rising edge restarts the sequence |
| sensor_id_i | input | 5 | Sensor identifier placed in each record |
| len_code_i | input | 2 | Data-length code placed in each record |
| sample_i | input | 16 | Converter sample |
| test_mode_i | input | 1 | Replaces the sample with the fixed test word |
| rec_valid_o | output | 1 | A record is offered |
| rec_ready_i | input | 1 | The downstream side accepts the offered record |
| rec_data_o | output | 32 | Record word |
| overflow_o | output | 1 | Sticky flag: at least one record was dropped |

## Verification
The hardest case to reach is an overflow whose dropped periods still advance the timestamp, followed by a restart that must clear both the timestamp and the flag. The bench holds ready low across several due edges, so that one record stays parked while later ones are discarded. It then releases ready and checks that the next delivered timestamp has skipped exactly the dropped periods. Finally it toggles the enable and checks that the flag clears and the count starts again from zero. A separate sweep of more than 512 back-to-back records, with a short prescaler, covers the timestamp wrap and every id and length-code value.

// File: rtl/recpack_pkg.sv
package recpack_pkg;
  localparam int ID_W  = 5;
  localparam int LEN_W = 2;
  localparam int TS_W  = 9;
  localparam int SMP_W = 16;
  localparam int REC_W = ID_W + LEN_W + TS_W + SMP_W;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [LEN_W-1:0] len;
    logic [TS_W-1:0]  stamp;
    logic [SMP_W-1:0] smp;
  } record_t;

  // Field order from the top bit: id, length code, timestamp, sample.
  function automatic record_t form_record(input logic [ID_W-1:0]  id,
                                          input logic [LEN_W-1:0] len,
                                          input logic [TS_W-1:0]  stamp,
                                          input logic [SMP_W-1:0] smp);
    record_t r;
    r.id    = id;
    r.len   = len;
    r.stamp = stamp;
    r.smp   = smp;
    return r;
  endfunction

  // Timestamp step; the modulo-512 wrap follows from the field width.
  function automatic logic [TS_W-1:0] next_stamp(input logic [TS_W-1:0] s);
    return s + {{(TS_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/period_timer.sv
module period_timer #(
  parameter int PERIOD_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic due
);
  localparam int CW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !run)
      cnt <= '0;
    else if (cnt == LAST)
      cnt <= '0;
    else
      cnt <= cnt + CW'(1);
  end

  assign due = run && !restart && (cnt == LAST);

  generate
    if (PERIOD_CYCLES > 1) begin : g_gap
      // R2
      period_gap_chk: assert property (@(posedge clk) disable iff (rst)
        due |=> !due);
    end
  endgenerate
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter
  import recpack_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            advance,
  output logic [TS_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      stamp <= '0;
    else if (advance)
      stamp <= next_stamp(stamp);
  end

  // R3
  stamp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!advance && !clear) |=> $stable(stamp));
endmodule

// File: rtl/record_slot.sv
module record_slot
  import recpack_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_ovf,
  input  logic             load_req,
  input  record_t          rec_in,
  input  logic             ready,
  output logic             valid,
  output logic [REC_W-1:0] data,
  output logic             overflow,
  output logic             drop
);
  logic take;
  logic accept;

  assign take   = valid && ready;
  assign accept = load_req && (!valid || ready);
  assign drop   = load_req && valid && !ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (accept) begin
      valid <= 1'b1;
      data  <= rec_in;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_ovf)
      overflow <= 1'b0;
    else if (drop)
      overflow <= 1'b1;
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(valid && !ready));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clear_ovf) |=> overflow);
endmodule

// File: rtl/sample_record_packer.sv
module sample_record_packer
  import recpack_pkg::*;
#(
  parameter int          PERIOD_CYCLES = 6250,
  parameter logic [15:0] TEST_WORD     = 16'h5A93
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sample_en_i,
  input  logic [4:0]  sensor_id_i,
  input  logic [1:0]  len_code_i,
  input  logic [15:0] sample_i,
  input  logic        test_mode_i,
  output logic        rec_valid_o,
  input  logic        rec_ready_i,
  output logic [31:0] rec_data_o,
  output logic        overflow_o
);
  logic            en_q;
  logic            start;
  logic            due;
  logic            drop;
  logic [TS_W-1:0] stamp;
  logic [SMP_W-1:0] smp_sel;
  record_t         rec_new;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= sample_en_i;
  end

  assign start   = sample_en_i && !en_q;
  assign smp_sel = test_mode_i ? TEST_WORD : sample_i;
  assign rec_new = form_record(sensor_id_i, len_code_i, stamp, smp_sel);

  period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (sample_en_i),
    .restart (start),
    .due     (due)
  );

  stamp_counter i_stamp (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .advance (due),
    .stamp   (stamp)
  );

  record_slot i_slot (
    .clk       (clk),
    .rst       (rst),
    .clear_ovf (start),
    .load_req  (due),
    .rec_in    (rec_new),
    .ready     (rec_ready_i),
    .valid     (rec_valid_o),
    .data      (rec_data_o),
    .overflow  (overflow_o),
    .drop      (drop)
  );

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (stamp == '0 && !overflow_o));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!sample_en_i && !rec_valid_o) |=> !rec_valid_o);
  // R7
  drop_advances_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> (overflow_o && stamp == next_stamp($past(stamp))));
endmodule

// File: tb/test_sample_record_packer.sv
module test_sample_record_packer;
  localparam int          P  = 5;
  localparam logic [15:0] TW = 16'h5A93;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [4:0]  id = '0;
  logic [1:0]  lc = '0;
  logic [15:0] smp = '0;
  logic        tm = 1'b0;
  logic        rdy = 1'b1;
  logic        vld;
  logic [31:0] dat;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sample_record_packer #(.PERIOD_CYCLES(P), .TEST_WORD(TW)) i_sample_record_packer (
    .clk(clk), .rst(rst), .sample_en_i(en), .sensor_id_i(id), .len_code_i(lc),
    .sample_i(smp), .test_mode_i(tm), .rec_valid_o(vld), .rec_ready_i(rdy),
    .rec_data_o(dat), .overflow_o(ovf));

  function automatic logic [31:0] expect_word(int i, int l, int t, int s);
    return (32'(i) << 27) | (32'(l) << 25) | (32'(t % 512) << 16) | 32'(s & 16'hFFFF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 valid", 32'(vld), 0);
    check("R9 data", dat, 0);
    check("R9 overflow", 32'(ovf), 0);
    rst = 1'b0;
    @(negedge clk);

    // Sweep: 520 records, ready always high, covers wrap, all ids and codes (R1 R2 R3 R5)
    en = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 520; k++) begin
      repeat (P-1) @(posedge clk);
      @(negedge clk);
      check("R2 no record before due", 32'(vld), 0);
      id  = 5'(k % 32);
      lc  = 2'((k / 32) % 4);
      smp = 16'(k * 37 + 11);
      tm  = (k % 3 == 0);
      @(posedge clk);
      @(negedge clk);
      check("R2 record due", 32'(vld), 1);
      check(tm ? "R5 test word" : "R1 R3 record fields", dat,
            expect_word(k % 32, (k / 32) % 4, k, tm ? int'(TW) : k * 37 + 11));
      if (k == 512) check("R3 wrap to zero", 32'(dat[24:16]), 0);
    end
    check("R7 no overflow with ready high", 32'(ovf), 0);
    tm = 1'b0;

    // Enable low: nothing new appears (R4)
    en = 1'b0;
    for (int c = 0; c < 3*P; c++) begin
      @(posedge clk);
      @(negedge clk);
      check("R4 quiet while disabled", 32'(vld), 0);
    end

    // Backpressure and drops (R6 R7), then restart (R8)
    rdy = 1'b0; id = 5'd9; lc = 2'd2; smp = 16'hBEEF;
    en = 1'b1;
    @(posedge clk);
    repeat (P) @(posedge clk);
    @(negedge clk);
    check("R8 first record after restart", dat, expect_word(9, 2, 0, 16'hBEEF));
    check("R6 offered", 32'(vld), 1);
    check("R7 no overflow yet", 32'(ovf), 0);
    smp = 16'h1234;
    repeat (P) @(posedge clk);
    @(negedge clk);
    check("R7 overflow set", 32'(ovf), 1);
    check("R6 held data", dat, expect_word(9, 2, 0, 16'hBEEF));
    repeat (2*P) @(posedge clk);
    @(negedge clk);
    check("R6 still held", dat, expect_word(9, 2, 0, 16'hBEEF));
    check("R6 still valid", 32'(vld), 1);
    rdy = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 valid falls after take", 32'(vld), 0);
    repeat (P-1) @(posedge clk);
    @(negedge clk);
    check("R7 timestamp skipped drops", dat, expect_word(9, 2, 4, 16'h1234));
    check("R7 overflow sticky", 32'(ovf), 1);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 overflow cleared", 32'(ovf), 0);
    check("R8 no early record", 32'(vld), 0);
    repeat (P) @(posedge clk);
    @(negedge clk);
    check("R8 timestamp restarted", dat, expect_word(9, 2, 0, 16'h1234));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule